// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Front End

This block is the device-side command decoder of a serial NOR flash, limited to the instructions that lead to a whole-array erase. The host frames each instruction with an active-low select. An 8-bit opcode is shifted in on one data line, most significant bit first, and sampled on the rising serial clock. Replies go out on the falling edge, as in SPI mode 0. The block keeps a small status byte made of a busy flag, a write-enable latch and a three-bit protection field. A write-enable opcode sets the latch. A status-read opcode streams the status byte out for as long as select stays low. An erase opcode starts a timed whole-array erase, which leaves every array byte at FFh, but only when all of its gating conditions hold.

All serial inputs are brought into the system clock domain through synchronizer chains, and edges are detected there. The erase itself is modelled by a countdown stub that stays busy for a parameterized number of system clocks. The protection field is fixed by a parameter, because no instruction that writes it is in scope.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 00h when the protection parameter is zero, `erase_active` is low and `spi_miso` is low.
- R2: Opcode 06h (enable writes), shifted in while the block is idle, sets the write-enable latch, which is status bit 1.
- R3: Opcode 05h makes the block return the status byte MSB first, one bit per falling clock edge. Bit 0 is busy, bit 1 is the write-enable latch, bits 2 to 4 are the protection field (lowest protection bit at bit 2) and bits 5 to 7 are zero. The byte repeats for as long as select stays low.
- R4: Opcode C7h starts the erase when all of these hold: select rises after exactly 8 clocked bits, the write-enable latch is set, the protection field is zero and no erase is already running. `erase_active` then rises and status bit 0 reads 1.
- R5: The erase keeps `erase_active` high for exactly ERASE_CYCLES system clocks. Afterwards status bit 0 reads 0.
- R6: The write-enable latch is cleared when the erase starts, so status reads 01h during the erase.
- R7: Opcode C7h is ignored when the write-enable latch is clear.
- R8: Opcode C7h is ignored when select rises after any bit count other than 8 (for example 7 or 9). The write-enable latch is left unchanged.
- R9: Opcode C7h is ignored when any protection bit is set. No erase starts and the status byte is unchanged.
- R10: While an erase runs, every opcode other than 05h is ignored. The status byte remains readable.
- R11: An opcode other than 06h, 05h or C7h changes no state.
- R12: `spi_miso` is driven low while select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low instruction frame select |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial instruction data in |
| spi_miso | output | 1 | Serial status data out |
| erase_active | output | 1 | High while the timed erase runs |

## Verification
The bench builds two instances that share one serial bus. The first has the protection field at zero and ERASE_CYCLES at 1500. That window is long enough to complete several full status reads and rejected opcodes while the erase is running, and short enough to time exactly. The second sets the protection field to 010b, so the protected-rejection path and a nonzero protection field in the status byte are checked against the same stimulus. Both use two synchronizer stages and a serial half-period of six system clocks, which leaves margin for the synchronizer and edge-detect latency before each sample.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

   localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
   localparam logic [7:0] OPC_RD_STATUS = 8'h05;
   localparam logic [7:0] OPC_ERASE_ALL = 8'hC7;

   // status byte as seen on the serial output, MSB first
   typedef struct packed {
      logic [2:0] spare;
      logic [2:0] prot;
      logic       wen;
      logic       busy;
   } stat_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bit_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("bit_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_front.sv
module spi_front #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   input  logic       tx_en,
   input  logic [7:0] tx_byte,
   output logic       miso,
   output logic       sel_fall,
   output logic       sel_rise,
   output logic       op_valid,
   output logic [7:0] op_byte,
   output logic       exact8
);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("spi_front: CNT_W must hold a count of 9");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_7   = CNT_W'(7);
   localparam logic [CNT_W-1:0] CNT_8   = CNT_W'(8);

   logic [2:0] raw, syn;
   logic cs_s, sck_s, mosi_s, cs_d, sck_d;
   logic sck_rise, sck_fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0] shreg;
   logic [2:0] tx_idx;
   logic miso_q;

   assign raw = {cs_n, sck, mosi};

   bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
   );

   assign {cs_s, sck_s, mosi_s} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign sel_fall = cs_d & ~cs_s;
   assign sel_rise = ~cs_d & cs_s;
   assign sck_rise = ~cs_s & sck_s & ~sck_d;
   assign sck_fall = ~cs_s & ~sck_s & sck_d;

   // bit counter saturates so any count past 8 stays "not exactly 8"
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         op_valid <= 1'b0;
      end else begin
         op_valid <= sck_rise && (bit_cnt == CNT_7);
         if (sel_fall) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[6:0], mosi_s};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign op_byte = shreg;
   assign exact8  = (bit_cnt == CNT_8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_idx <= 3'd7;
         miso_q <= 1'b0;
      end else if (cs_s) begin
         tx_idx <= 3'd7;
         miso_q <= 1'b0;
      end else if (sck_fall && tx_en) begin
         miso_q <= tx_byte[tx_idx];
         tx_idx <= tx_idx - 1'b1;
      end
   end

   assign miso = miso_q;

   assert_miso_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !miso_q);

   assert_opcode_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> exact8);

endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
   parameter int CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("erase_timer: CYCLES must be at least 1");
   end

   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (start)           remain <= LOAD;
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // checker: independent length of the busy run
   logic [CW:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_len <= '0;
      else if (busy)  run_len <= run_len + 1'b1;
      else            run_len <= '0;
   end

   assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == (CW+1)'(CYCLES)));

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
   import flash_erase_pkg::*;
#(
   parameter int         ERASE_CYCLES = 4096,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [2:0] PROT_INIT    = 3'b000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic erase_active
);

   localparam logic PROT_CLEAR = (PROT_INIT == 3'b000);

   logic sel_fall, sel_rise, op_valid, exact8;
   logic [7:0] op_byte;
   logic wen, rd_active, erase_armed, erase_start, busy;
   stat_t stat;

   assign stat = '{spare: 3'b000, prot: PROT_INIT, wen: wen, busy: busy};

   spi_front #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(4)) i_front (
      .clk(clk), .rst_n(rst_n),
      .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
      .tx_en(rd_active), .tx_byte(stat),
      .miso(spi_miso),
      .sel_fall(sel_fall), .sel_rise(sel_rise),
      .op_valid(op_valid), .op_byte(op_byte), .exact8(exact8)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_active   <= 1'b0;
         erase_armed <= 1'b0;
      end else if (sel_fall || sel_rise) begin
         rd_active   <= 1'b0;
         erase_armed <= 1'b0;
      end else if (op_valid) begin
         case (op_byte)
            OPC_RD_STATUS: rd_active   <= 1'b1;
            OPC_ERASE_ALL: erase_armed <= !busy;
            default: ;
         endcase
      end
   end

   assign erase_start = sel_rise && erase_armed && exact8 && wen
                        && PROT_CLEAR && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wen <= 1'b0;
      else if (erase_start)
         wen <= 1'b0;
      else if (op_valid && (op_byte == OPC_WR_ENABLE) && !busy)
         wen <= 1'b1;
   end

   erase_timer #(.CYCLES(ERASE_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(erase_start), .busy(busy)
   );

   assign erase_active = busy;

   assert_wen_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !wen);

   assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> (wen && !busy && exact8));

   assert_busy_holds_wen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wen) |=> !wen);

   if (!PROT_CLEAR) begin : g_protected
      assert_protected_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !erase_active);
   end

endmodule

// File: tb/test_flash_erase_ctrl.sv
`timescale 1ns/1ps
module test_flash_erase_ctrl;

   localparam int HALF   = 6;
   localparam int ECYC   = 1500;

   typedef struct packed {
      logic [7:0] op;
      logic [3:0] nbits;
      logic [7:0] exp_a;
      logic [7:0] exp_b;
      logic [3:0] req;
   } vec_t;

   // each entry: send op with nbits, then read status once on both parts
   localparam vec_t VEC [8] = '{
      '{8'h05, 4'd8, 8'h00, 8'h08, 4'd1},   // R1 / R3 reset status
      '{8'hA5, 4'd8, 8'h00, 8'h08, 4'd11},  // R11 unknown opcode
      '{8'h06, 4'd8, 8'h02, 8'h0A, 4'd2},   // R2 enable writes
      '{8'hC7, 4'd9, 8'h02, 8'h0A, 4'd8},   // R8 nine bits
      '{8'hC7, 4'd7, 8'h02, 8'h0A, 4'd8},   // R8 seven bits
      '{8'hC7, 4'd8, 8'h01, 8'h0A, 4'd6},   // R6 / R4 start, R9 on protected
      '{8'h06, 4'd8, 8'h01, 8'h0A, 4'd10},  // R10 enable ignored while busy
      '{8'hC7, 4'd8, 8'h01, 8'h0A, 4'd10}   // R10 erase ignored while busy
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso_a, miso_b, ea_a, ea_b;

   int total = 0, bad = 0;
   int run_a = 0, last_len = 0, rise_a = 0, rise_b = 0;
   logic prev_a = 1'b0, prev_b = 1'b0;
   bit done = 0;

   always #2.5 clk = ~clk;

   flash_erase_ctrl #(.ERASE_CYCLES(ECYC), .SYNC_STAGES(2), .PROT_INIT(3'b000)) i_flash_erase_ctrl (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso_a), .erase_active(ea_a)
   );

   flash_erase_ctrl #(.ERASE_CYCLES(ECYC), .SYNC_STAGES(2), .PROT_INIT(3'b010)) i_flash_erase_ctrl_prot (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso_b), .erase_active(ea_b)
   );

   always @(negedge clk) begin
      if (ea_a) run_a++;
      else if (run_a != 0) begin last_len = run_a; run_a = 0; end
      if (ea_a && !prev_a) rise_a++;
      if (ea_b && !prev_b) rise_b++;
      prev_a = ea_a;
      prev_b = ea_b;
   end

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input int act, input int exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic spi_cmd(input logic [7:0] op, input int nbits, input int nread,
                          output logic [7:0] first_a, output logic [7:0] last_a,
                          output logic [7:0] last_b);
      logic [7:0] ra = '0, rb = '0;
      first_a = '0;
      cs_n = 1'b0;
      wclk(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 8) ? op[7-i] : 1'b0;
         wclk(HALF);
         sck = 1'b1;
         wclk(HALF);
         sck = 1'b0;
      end
      for (int r = 0; r < nread; r++) begin
         for (int b = 0; b < 8; b++) begin
            wclk(HALF);
            ra = {ra[6:0], miso_a};
            rb = {rb[6:0], miso_b};
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
         end
         if (r == 0) first_a = ra;
      end
      last_a = ra;
      last_b = rb;
      wclk(HALF);
      cs_n = 1'b1;
      mosi = 1'b0;
      wclk(2*HALF);
   endtask

   task automatic read_status(input string tag, input logic [7:0] ea, input logic [7:0] eb);
      logic [7:0] f, la, lb;
      spi_cmd(8'h05, 8, 1, f, la, lb);
      chk(la, ea, {tag, " status"});
      chk(lb, eb, {tag, " protected status"});
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         finish_run();
      end
   end

   initial begin
      logic [7:0] f, la, lb;
      wclk(10);
      rst_n = 1'b1;
      wclk(4);
      // R1 reset state at the ports
      chk(ea_a, 0, "R1 erase_active");
      chk(miso_a, 0, "R1 miso");

      foreach (VEC[k]) begin
         spi_cmd(VEC[k].op, int'(VEC[k].nbits), 0, f, la, lb);
         spi_cmd(8'h05, 8, 1, f, la, lb);
         chk(la, VEC[k].exp_a, $sformatf("R%0d vector %0d", VEC[k].req, k));
         chk(lb, VEC[k].exp_b, $sformatf("R%0d vector %0d protected", VEC[k].req, k));
      end

      // R4 erase started exactly once, R9 protected part never started
      chk(rise_a, 1, "R4 erase start count");
      chk(ea_a, 1, "R4 erase still active");
      chk(rise_b, 0, "R9 protected erase count");

      while (ea_a) wclk(1);
      wclk(2);
      chk(last_len, ECYC, "R5 erase length");
      read_status("R5 after erase", 8'h00, 8'h0A);

      // R7 erase without the latch
      spi_cmd(8'hC7, 8, 0, f, la, lb);
      wclk(20);
      chk(ea_a, 0, "R7 erase_active");
      chk(rise_a, 1, "R7 erase start count");
      read_status("R7", 8'h00, 8'h0A);

      // R3 repeating status bytes while select stays low
      spi_cmd(8'h06, 8, 0, f, la, lb);
      spi_cmd(8'h05, 8, 2, f, la, lb);
      chk(f, 8'h02, "R3 first byte");
      chk(la, 8'h02, "R3 repeated byte");
      chk(lb, 8'h0A, "R3 protected byte");

      // R12 output idle while select high
      wclk(5);
      chk(miso_a, 0, "R12 miso");
      chk(miso_b, 0, "R12 protected miso");
      chk(rise_b, 0, "R9 protected erase count final");

      done = 1;
      finish_run();
   end

endmodule